// File: doc/BRIEF.md
# JTAG Configuration Status Readback Sequencer

This block is a JTAG master that reads one 32-bit configuration status word from a single target on the scan chain. A one-cycle `start` request launches a fixed, scripted walk of the target's TAP controller:

- It forces the TAP into Test-Logic-Reset.
- It selects the configuration-input instruction and pushes a short command stream into that data register. The stream is a synchronisation word, a no-operation word, a one-word status-read request and two trailing no-operation words.
- It selects the configuration-output instruction and clocks the reply word out of TDO.
- It parks the TAP in Test-Logic-Reset again.

TCK is a divided copy of the system clock. A clock-enable divider sets the half period to `HALF_DIV` system cycles.

The result is offered on a plain output word together with a one-cycle `done` strobe. There is no ready input and no back-pressure. The word stays on `status_word` until the next accepted `start`, so the consumer may take it in the `done` cycle or at any later time. `busy` tells the requester when a new `start` will be accepted.

Top module: `jtag_stat_reader`

## Requirements
- R1: After reset and whenever idle, `busy`=0, `done`=0, `tck`=0, `tms`=1 and `tdi`=0.
- R2: Each TCK level lasts `HALF_DIV` system clocks. `tms` and `tdi` change only while `tck` is low. `tdo` is sampled on the system clock edge that raises `tck`.
- R3: A run opens with TMS values 1,1,1,1,1,0 on the first six TCK rises, then 1,1,0,0 to reach Shift-IR.
- R4: The first instruction loaded is `CFG_IN_OP` (default 10'h3C5). The instruction goes out LSB first over `IR_LEN` rises, with TMS high only on the last rise.
- R5: While the first instruction is active, 160 data bits are shifted in with TMS high only on the last bit. The bits are the words AA995566, 20000000, 2800E001, 20000000, 20000000 (hex), in that order, each MSB first.
- R6: The second instruction loaded is `CFG_OUT_OP` (default 10'h3C4).
- R7: The 32 bits read from TDO in the second Shift-DR form `status_word`. The first bit read becomes bit 31.
- R8: A run consists of exactly 245 TCK rises (with `IR_LEN`=10) and leaves the target TAP in Test-Logic-Reset.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, the same cycle in which `busy` falls.
- R10: `start` while `busy` is high has no effect on the running sequence or its result.
- R11: `status_word` holds its value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one status readback |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe: status word valid |
| status_word | output | 32 | Captured status word |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The case that matters is a new request arriving in the same cycle that the previous run completes. In that cycle `done` is high and `busy` has just dropped, so the block must both finish the old run and accept the new one. The bench provokes this by holding `start` high through a whole run and beyond its `done` cycle. It then judges that the held request was ignored while busy: the first run has exactly 245 rises and returns the first status value. It also judges that the same request started a second, complete run, which returns a different status value loaded into the behavioural target model after the first `done`.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
  localparam int WORD_W    = 32;
  localparam int PKT_WORDS = 5;
  localparam int PKT_BITS  = WORD_W * PKT_WORDS;

  // Command stream pushed through the configuration-input register.
  function automatic logic [WORD_W-1:0] pkt_word(input int idx);
    case (idx)
      0:       return 32'hAA995566;
      2:       return 32'h2800E001;
      default: return 32'h20000000;
    endcase
  endfunction

  // Total TCK rises in one scripted run.
  function automatic int steps_total(input int ir_len);
    return 5 + 1 + 4 + ir_len + 4 + PKT_BITS + 5 + ir_len + 4 + WORD_W + 5 + 5;
  endfunction
endpackage

// File: rtl/jsr_tck_gen.sv
module jsr_tck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/jsr_script.sv
module jsr_script
  import jsr_pkg::*;
#(
  parameter int                IR_LEN     = 10,
  parameter logic [IR_LEN-1:0] CFG_IN_OP  = 10'h3C5,
  parameter logic [IR_LEN-1:0] CFG_OUT_OP = 10'h3C4,
  parameter int                STEP_W     = 8
) (
  input  logic [STEP_W-1:0] step,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              cap_o
);
  localparam int S_RTI   = 5;
  localparam int S_TOIR1 = S_RTI + 1;
  localparam int S_IR1   = S_TOIR1 + 4;
  localparam int S_TODR1 = S_IR1 + IR_LEN;
  localparam int S_PKT   = S_TODR1 + 4;
  localparam int S_TOIR2 = S_PKT + PKT_BITS;
  localparam int S_IR2   = S_TOIR2 + 5;
  localparam int S_TODR2 = S_IR2 + IR_LEN;
  localparam int S_CAP   = S_TODR2 + 4;
  localparam int S_TOIR3 = S_CAP + WORD_W;
  localparam int S_RST   = S_TOIR3 + 5;

  int                s;
  int                off;
  logic [IR_LEN-1:0] op_sh;
  logic [WORD_W-1:0] wd_sh;

  always_comb begin
    s     = int'(step);
    off   = 0;
    op_sh = '0;
    wd_sh = '0;
    tms_o = 1'b1;
    tdi_o = 1'b0;
    cap_o = 1'b0;
    if (s < S_RTI) begin
      tms_o = 1'b1;
    end else if (s < S_TOIR1) begin
      tms_o = 1'b0;
    end else if (s < S_IR1) begin
      tms_o = (s - S_TOIR1) < 2;
    end else if (s < S_TODR1) begin
      off   = s - S_IR1;
      op_sh = CFG_IN_OP >> off;
      tdi_o = op_sh[0];
      tms_o = (off == IR_LEN - 1);
    end else if (s < S_PKT) begin
      tms_o = (s - S_TODR1) < 2;
    end else if (s < S_TOIR2) begin
      off   = s - S_PKT;
      wd_sh = pkt_word(off / WORD_W) >> (WORD_W - 1 - (off % WORD_W));
      tdi_o = wd_sh[0];
      tms_o = (off == PKT_BITS - 1);
    end else if (s < S_IR2) begin
      tms_o = (s - S_TOIR2) < 3;
    end else if (s < S_TODR2) begin
      off   = s - S_IR2;
      op_sh = CFG_OUT_OP >> off;
      tdi_o = op_sh[0];
      tms_o = (off == IR_LEN - 1);
    end else if (s < S_CAP) begin
      tms_o = (s - S_TODR2) < 2;
    end else if (s < S_TOIR3) begin
      off   = s - S_CAP;
      cap_o = 1'b1;
      tms_o = (off == WORD_W - 1);
    end else if (s < S_RST) begin
      tms_o = (s - S_TOIR3) < 3;
    end else begin
      tms_o = 1'b1;
    end
  end
endmodule

// File: rtl/jsr_capture.sv
module jsr_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (clear)    word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/jtag_stat_reader.sv
module jtag_stat_reader
  import jsr_pkg::*;
#(
  parameter int                HALF_DIV   = 2,
  parameter int                IR_LEN     = 10,
  parameter logic [IR_LEN-1:0] CFG_IN_OP  = 10'h3C5,
  parameter logic [IR_LEN-1:0] CFG_OUT_OP = 10'h3C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] status_word,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  localparam int N_STEPS = steps_total(IR_LEN);
  localparam int STEP_W  = $clog2(N_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic              busy_q, done_q, tck_q, tms_q, tdi_q, cap_q;
  logic [STEP_W-1:0] step_q, sidx;
  logic              tick, s_tms, s_tdi, s_cap;
  logic              accept, rise_now;

  assign accept   = start && !busy_q;
  assign rise_now = busy_q && tick && !tck_q;
  assign sidx     = busy_q ? step_q + 1'b1 : '0;

  jsr_tck_gen #(.HALF_DIV(HALF_DIV)) tck_gen_i (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .tick(tick)
  );

  jsr_script #(
    .IR_LEN(IR_LEN), .CFG_IN_OP(CFG_IN_OP), .CFG_OUT_OP(CFG_OUT_OP), .STEP_W(STEP_W)
  ) script_i (
    .step(sidx), .tms_o(s_tms), .tdi_o(s_tdi), .cap_o(s_cap)
  );

  jsr_capture #(.W(WORD_W)) capture_i (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .shift_en(rise_now && cap_q), .bit_in(tdo), .word(status_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tck_q  <= 1'b0;
      tms_q  <= 1'b1;
      tdi_q  <= 1'b0;
      cap_q  <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        tck_q  <= 1'b0;
        tms_q  <= s_tms;
        tdi_q  <= s_tdi;
        cap_q  <= s_cap;
      end else if (busy_q && tick) begin
        if (!tck_q) begin
          tck_q <= 1'b1;
        end else begin
          tck_q <= 1'b0;
          if (step_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            tms_q  <= 1'b1;
            tdi_q  <= 1'b0;
            cap_q  <= 1'b0;
          end else begin
            step_q <= step_q + 1'b1;
            tms_q  <= s_tms;
            tdi_q  <= s_tdi;
            cap_q  <= s_cap;
          end
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign tck  = tck_q;
  assign tms  = tms_q;
  assign tdi  = tdi_q;
endmodule

// File: rtl/jsr_checker.sv
module jsr_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi
);
  // R2: pins to the target never move while TCK is high
  a_r2_pins_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdi)));
  // R1: idle parks TCK low and TMS high
  a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tck && tms && !tdi));
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10: a request during a run neither stops nor restarts it
  a_r10_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind jtag_stat_reader jsr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/jtag_stat_reader_tb_top.sv
module jtag_stat_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IRL = 10;
  localparam logic [IRL-1:0] OP_IN  = 10'h3C5;
  localparam logic [IRL-1:0] OP_OUT = 10'h3C4;
  localparam logic [159:0] PKT_EXP =
    {32'hAA995566, 32'h20000000, 32'h2800E001, 32'h20000000, 32'h20000000};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, tck, tms, tdi;
  logic tdo = 1'b0;
  logic [31:0] status_word;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_stat_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status_word(status_word), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // Behavioural single-device TAP target
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} tap_t;
  tap_t tap = TLR;
  logic [IRL-1:0] ir_sh = '0, ir_cur = '0, ir_l0 = '0, ir_l1 = '0, ir_l2 = '0;
  logic [159:0] pkt = '0;
  logic [31:0] dr = '0, stat_val = '0;
  logic [255:0] hist = '0;
  int rises = 0;

  function automatic tap_t nxt(tap_t s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (tap == SHIR) ir_sh <= {tdi, ir_sh[IRL-1:1]};
    if (tap == UIR) begin
      ir_cur <= ir_sh; ir_l0 <= ir_sh; ir_l1 <= ir_l0; ir_l2 <= ir_l1;
    end
    if (tap == TLR) ir_cur <= '0;
    if (tap == CDR && ir_cur == OP_OUT) dr <= stat_val;
    if (tap == SHDR && ir_cur == OP_IN)  pkt <= {pkt[158:0], tdi};
    if (tap == SHDR && ir_cur == OP_OUT) dr <= {dr[30:0], 1'b0};
    hist[rises[7:0]] <= tms;
    rises <= rises + 1;
    tap <= nxt(tap, tms);
  end

  always @(negedge tck) tdo <= (tap == SHDR && ir_cur == OP_OUT) ? dr[31] : 1'b0;

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int width);
    width = 0;
    while (!done) @(negedge clk);
    while (done) begin width++; @(negedge clk); end
  endtask

  // Judge one finished run; status sampled in the done cycle by caller
  task automatic judge(input logic [31:0] v, input logic [31:0] got, input int base);
    check(got == v, "R7 status word", got, v);
    check(ir_l2 == OP_IN, "R4 first instruction", ir_l2, OP_IN);
    check(ir_l1 == OP_OUT, "R6 second instruction", ir_l1, OP_OUT);
    check(pkt == PKT_EXP, "R5 packet stream", pkt, PKT_EXP);
    check(rises - base == 245, "R8 rise count", rises - base, 245);
    check(tap == TLR, "R8 final TAP state", tap, TLR);
    for (int k = 0; k < 10; k++) begin
      logic e;
      e = (k < 5) || k == 6 || k == 7;
      check(hist[8'(base + k)] == e, "R3 opening TMS", hist[8'(base + k)], e);
    end
  endtask

  task automatic one_run(input logic [31:0] v, input bit poke);
    int base, w;
    logic [31:0] got;
    stat_val = v;
    base = rises;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R10 still busy", busy, 1);
    end
    while (!done) @(negedge clk);
    got = status_word;
    wait_done(w);
    check(w == 1, "R9 done width", w, 1);
    judge(v, got, base);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int t0, th, base2, w;
    logic [31:0] got;
    repeat (3) @(negedge clk);
    check({busy, done, tck, tms, tdi} == 5'b00010, "R1 reset state",
          {busy, done, tck, tms, tdi}, 5'b00010);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: TCK half period in system clocks
    stat_val = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!tck) @(negedge clk);
    t0 = $time;
    while (tck) @(negedge clk);
    th = ($time - t0) / CLK_PERIOD;
    check(th == 2, "R2 TCK high length", th, 2);
    wait_done(w);

    // sweep: walking ones, all-zero, all-one, arithmetic patterns
    for (int k = 0; k < 42; k++) begin
      logic [31:0] v;
      if (k < 32) v = 32'h1 << k;
      else if (k == 32) v = 32'h0;
      else if (k == 33) v = 32'hFFFFFFFF;
      else v = 32'(k * 32'h9E3779B9);
      one_run(v, k == 35);
    end

    // R11: result holds after done
    got = status_word;
    repeat (60) @(negedge clk);
    check(status_word == got, "R11 status held", status_word, got);
    check(tck == 1'b0 && busy == 1'b0, "R1 idle after run", {busy, tck}, 0);

    // start held across a whole run and into its done cycle
    stat_val = 32'hC0FFEE11;
    base2 = rises;
    start = 1'b1;
    while (!done) @(negedge clk);
    got = status_word;
    judge(32'hC0FFEE11, got, base2);
    stat_val = 32'h5A5A0FF0;
    base2 = rises;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 restart in done cycle", busy, 1);
    while (!done) @(negedge clk);
    got = status_word;
    judge(32'h5A5A0FF0, got, base2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule